// File: doc/BRIEF.md
# Double-Buffered Video Control Register Bank

This block is the byte-wide control register file of a video processing pipeline. The host writes through a simple address/data port. Every write lands in a shadow copy. The pipeline only sees the active copy. Registers are split into three timing groups: main input, secondary input and output. Each group switches its settings at its own frame or field boundary, signalled by a one-cycle take-over strobe. Shadow data move to the active copy only after the host arms the group with a store command and the group's next strobe then arrives. This way a whole set of related settings changes at one picture boundary.

A status byte lets the host poll whether each group still has an armed store waiting. The same byte carries two sticky event flags. One flag says a fresh noise measurement is available. The other says the letterbox detection results have changed. Reading the status byte clears both event flags. Accesses to addresses with no register behind them are absorbed without any error.

Top module: `vsr_ctrl_bank`

## Requirements
- R1: A write to a mapped register changes only its shadow copy. A read of a mapped register returns the active copy, which keeps its value until that register's group commits.
- R2: Writing address 7Eh arms groups. Bit 0 arms main, bit 1 arms secondary and bit 2 arms output. Status (address 7Fh) bit 0, 1 or 2 reads 1 from the cycle after the store until the cycle after the group's commit, and reads 0 after that.
- R3: A group commits, copying every shadow byte to its active copy, on a take-over strobe while armed. A strobe while not armed changes nothing. A store and a strobe for the same group in the same cycle do not commit; the next strobe does.
- R4: Writing a register of an armed group again replaces the pending shadow value without any error. The commit delivers the most recent value.
- R5: A strobe for one group never changes the active registers or the pending bit of another group.
- R6: Status bit 3 is set by a noise-update pulse and stays set until a status read. A status read clears it, unless a new pulse arrives in the same cycle as the read, in which case it stays set.
- R7: Status bit 4 is set when any letterbox input differs from its value at the previous clock edge. The letterbox inputs are start line, end line, start-valid, end-valid and reliability. The bit is cleared by a status read in the same way as bit 3.
- R8: Addresses outside 00h–12h (main), 20h–27h (secondary), 37h–49h (output) and 7Fh read 00h, and writes to them are discarded. Address 7Eh also reads 00h. Status is read-only. Status bits 7 to 5 read 0.
- R9: After reset the following addresses hold non-zero values, in both shadow and active copies:
  - 04h=61h, 05h=88h, 07h=40h, 0Bh=69h, 0Dh=90h, 0Eh=B4h, 0Fh=B4h, 10h=90h, 12h=50h
  - 37h=48h, 38h=9Ch, 3Eh=5Ah, 3Fh=B4h, 40h=48h, 41h=90h, 43h=5Ah, 44h=B4h, 45h=B0h, 46h=10h, 47h=7Fh

  All other mapped registers hold 00h. After reset, pending bits and event flags are 0 and rdata is 00h.
- R10: Read data is registered. rdata takes the addressed value at the clock edge where rd_en is sampled high, and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| tko_main | input | 1 | Take-over strobe, main input group |
| tko_sec | input | 1 | Take-over strobe, secondary input group |
| tko_out | input | 1 | Take-over strobe, output group |
| nm_update | input | 1 | Pulse: new noise measurement ready |
| lb_start_line | input | LB_LINE_W | Letterbox detected start line |
| lb_end_line | input | LB_LINE_W | Letterbox detected end line |
| lb_start_ok | input | 1 | Letterbox start-line valid |
| lb_end_ok | input | 1 | Letterbox end-line valid |
| lb_reliab | input | LB_REL_W | Letterbox reliability value |

## Verification
The commit path is exercised with several kinds of stimulus:
- A single write followed by store and strobe. This separates the shadow copy from the active copy.
- A strobe that arrives without a store. This shows that commits are gated by arming.
- A store and a strobe in the same cycle. This tests the deferred-commit rule.
- A rewrite while the group is armed. This tells the overwrite rule apart from a first-value-wins design.
- A strobe for the wrong group. This exposes any cross-group leakage.

Event flags are driven with isolated pulses, repeated status reads, and an event coinciding with a read, so that set-priority and clear-on-read are distinguished. Each letterbox field is changed on its own so that every field's change detection is covered.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NGRP = 3;

  // group order: 0 main input, 1 secondary input, 2 output
  localparam logic [AW-1:0] GRP_BASE [NGRP] = '{8'h00, 8'h20, 8'h37};
  localparam int            GRP_CNT  [NGRP] = '{19, 8, 19};

  localparam logic [AW-1:0] CMD_ADDR  = 8'h7E;
  localparam logic [AW-1:0] STAT_ADDR = 8'h7F;

  function automatic logic [DW-1:0] reset_value(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    case (a)
      8'h04: v = 8'h61;
      8'h05: v = 8'h88;
      8'h07: v = 8'h40;
      8'h0B: v = 8'h69;
      8'h0D: v = 8'h90;
      8'h0E, 8'h0F: v = 8'hB4;
      8'h10: v = 8'h90;
      8'h12: v = 8'h50;
      8'h37, 8'h40: v = 8'h48;
      8'h38: v = 8'h9C;
      8'h3E, 8'h43: v = 8'h5A;
      8'h3F, 8'h44: v = 8'hB4;
      8'h41: v = 8'h90;
      8'h45: v = 8'hB0;
      8'h46: v = 8'h10;
      8'h47: v = 8'h7F;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/vsr_shadow_group.sv
module vsr_shadow_group
  import vsr_pkg::*;
#(
  parameter logic [7:0] BASE  = 8'h00,
  parameter int         COUNT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          store,
  input  logic          takeover,
  output logic          hit,
  output logic [DW-1:0] rd_val,
  output logic          pending
);
  logic [COUNT-1:0][DW-1:0] shadow_q, shadow_d;
  logic [COUNT-1:0][DW-1:0] active_q, active_d;
  logic                     pending_q, pending_d;
  logic [AW-1:0]            off;
  logic                     commit;

  assign off     = addr - BASE;
  assign hit     = (off < AW'(COUNT));
  assign commit  = takeover & pending_q & ~store;
  assign pending = pending_q;

  always_comb begin
    rd_val   = '0;
    shadow_d = shadow_q;
    for (int i = 0; i < COUNT; i++) begin
      if (off == AW'(i)) rd_val = active_q[i];
      if (wr_en && (off == AW'(i))) shadow_d[i] = wdata;
    end
    active_d  = commit ? shadow_q : active_q;
    pending_d = store | (pending_q & ~commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COUNT; i++) begin
        shadow_q[i] <= reset_value(BASE + AW'(i));
        active_q[i] <= reset_value(BASE + AW'(i));
      end
      pending_q <= 1'b0;
    end else begin
      shadow_q  <= shadow_d;
      active_q  <= active_d;
      pending_q <= pending_d;
    end
  end

  // R1: active copy only moves on a commit
  p_active_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));
  // R3: a commit delivers the shadow contents seen at the strobe
  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q == $past(shadow_q)));
  // R2: a store arms the group
  p_store_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> pending_q);
  // R2: armed state persists until a strobe
  p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !takeover) |=> pending_q);
  // R3: strobe without simultaneous store disarms
  p_strobe_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && takeover && !store) |=> !pending_q);
endmodule

// File: rtl/vsr_event_flags.sv
module vsr_event_flags #(
  parameter int LINE_W = 10,
  parameter int REL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nm_update,
  input  logic [LINE_W-1:0] lb_start_line,
  input  logic [LINE_W-1:0] lb_end_line,
  input  logic              lb_start_ok,
  input  logic              lb_end_ok,
  input  logic [REL_W-1:0]  lb_reliab,
  input  logic              clr,
  output logic              noise_flag,
  output logic              lb_flag
);
  localparam int LBW = 2 * LINE_W + 2 + REL_W;

  logic [LBW-1:0] lb_now, lb_prev_q;
  logic           noise_q, noise_d, lb_q, lb_d, lb_chg;

  assign lb_now     = {lb_start_line, lb_end_line, lb_start_ok, lb_end_ok, lb_reliab};
  assign lb_chg     = (lb_now != lb_prev_q);
  assign noise_flag = noise_q;
  assign lb_flag    = lb_q;

  always_comb begin
    noise_d = nm_update | (noise_q & ~clr);
    lb_d    = lb_chg | (lb_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noise_q   <= 1'b0;
      lb_q      <= 1'b0;
      lb_prev_q <= '0;
    end else begin
      noise_q   <= noise_d;
      lb_q      <= lb_d;
      lb_prev_q <= lb_now;
    end
  end

  // R6: a noise pulse always leaves the flag set, read or not
  p_noise_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nm_update |=> noise_q);
  // R6: a read with no new pulse clears the flag
  p_noise_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !nm_update) |=> !noise_q);
  // R7: letterbox flag is sticky without a read
  p_lb_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_q && !clr) |=> lb_q);
endmodule

// File: rtl/vsr_ctrl_bank.sv
module vsr_ctrl_bank
  import vsr_pkg::*;
#(
  parameter int LB_LINE_W = 10,
  parameter int LB_REL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic                 tko_main,
  input  logic                 tko_sec,
  input  logic                 tko_out,
  input  logic                 nm_update,
  input  logic [LB_LINE_W-1:0] lb_start_line,
  input  logic [LB_LINE_W-1:0] lb_end_line,
  input  logic                 lb_start_ok,
  input  logic                 lb_end_ok,
  input  logic [LB_REL_W-1:0]  lb_reliab
);
  logic [1:0]      rst_sync_q;
  logic            rst_i_n;
  logic [NGRP-1:0] tko, store, hit, pend;
  logic [DW-1:0]   grp_rd [NGRP];
  logic            stat_sel, cmd_wr, clr;
  logic            noise_flag, lb_flag;
  logic [DW-1:0]   status, rd_mux, rdata_q, rdata_d;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign tko      = {tko_out, tko_sec, tko_main};
  assign stat_sel = (addr == STAT_ADDR);
  assign cmd_wr   = wr_en & (addr == CMD_ADDR);
  assign store    = cmd_wr ? wdata[NGRP-1:0] : '0;
  assign clr      = rd_en & stat_sel;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    vsr_shadow_group #(
      .BASE (GRP_BASE[g]),
      .COUNT(GRP_CNT[g])
    ) u_grp (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .store   (store[g]),
      .takeover(tko[g]),
      .hit     (hit[g]),
      .rd_val  (grp_rd[g]),
      .pending (pend[g])
    );
  end

  vsr_event_flags #(
    .LINE_W(LB_LINE_W),
    .REL_W (LB_REL_W)
  ) u_events (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .nm_update    (nm_update),
    .lb_start_line(lb_start_line),
    .lb_end_line  (lb_end_line),
    .lb_start_ok  (lb_start_ok),
    .lb_end_ok    (lb_end_ok),
    .lb_reliab    (lb_reliab),
    .clr          (clr),
    .noise_flag   (noise_flag),
    .lb_flag      (lb_flag)
  );

  always_comb begin
    status = {3'b000, lb_flag, noise_flag, pend};
    rd_mux = stat_sel ? status : '0;
    for (int g = 0; g < NGRP; g++) begin
      if (hit[g]) rd_mux = rd_mux | grp_rd[g];
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && (hit == '0) && !stat_sel) |=> (rdata == '0));
  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_en |=> $stable(rdata));
  // R8: reserved status bits never set
  p_status_top_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && stat_sel) |=> (rdata[7:5] == 3'b000));
endmodule

// File: tb/tb_vsr_ctrl_bank.sv
`timescale 1ns/1ps
module tb_vsr_ctrl_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;
  logic       tko_main, tko_sec, tko_out, nm_update;
  logic [9:0] lb_s, lb_e;
  logic       lb_so, lb_eo;
  logic [3:0] lb_r;

  always #4 clk = ~clk;

  vsr_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tko_main(tko_main), .tko_sec(tko_sec),
    .tko_out(tko_out), .nm_update(nm_update), .lb_start_line(lb_s),
    .lb_end_line(lb_e), .lb_start_ok(lb_so), .lb_end_ok(lb_eo), .lb_reliab(lb_r)
  );

  // ---------------- reference model ----------------
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;
  string      cur_req = "R9";
  logic [7:0] m_sh [256];
  logic [7:0] m_ac [256];
  bit         m_pend [3];
  bit         m_noise, m_lb;
  logic [25:0] m_lbprev;
  logic [7:0] m_rdata;

  function automatic int grp_of(input logic [7:0] a);
    if (a <= 8'h12) return 0;
    if (a >= 8'h20 && a <= 8'h27) return 1;
    if (a >= 8'h37 && a <= 8'h49) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] dflt(input logic [7:0] a);
    case (a)
      8'h04: return 8'h61; 8'h05: return 8'h88; 8'h07: return 8'h40;
      8'h0B: return 8'h69; 8'h0D: return 8'h90; 8'h0E: return 8'hB4;
      8'h0F: return 8'hB4; 8'h10: return 8'h90; 8'h12: return 8'h50;
      8'h37: return 8'h48; 8'h38: return 8'h9C; 8'h3E: return 8'h5A;
      8'h3F: return 8'hB4; 8'h40: return 8'h48; 8'h41: return 8'h90;
      8'h43: return 8'h5A; 8'h44: return 8'hB4; 8'h45: return 8'hB0;
      8'h46: return 8'h10; 8'h47: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) begin
      m_sh[a] = (grp_of(8'(a)) >= 0) ? dflt(8'(a)) : 8'h00;
      m_ac[a] = m_sh[a];
    end
    for (int g = 0; g < 3; g++) m_pend[g] = 0;
    m_noise = 0; m_lb = 0; m_lbprev = '0; m_rdata = 8'h00;
  endtask

  task automatic model_step();
    bit          tk [3];
    bit          st [3];
    bit          cm [3];
    bit          clr;
    logic [25:0] lbv;
    tk[0] = tko_main; tk[1] = tko_sec; tk[2] = tko_out;
    for (int g = 0; g < 3; g++) begin
      st[g] = wr_en && (addr == 8'h7E) && wdata[g];
      cm[g] = tk[g] && m_pend[g] && !st[g];
    end
    clr = rd_en && (addr == 8'h7F);
    if (rd_en) begin
      if (addr == 8'h7F)
        m_rdata = {3'b000, m_lb, m_noise, m_pend[2], m_pend[1], m_pend[0]};
      else if (grp_of(addr) >= 0) m_rdata = m_ac[addr];
      else m_rdata = 8'h00;
    end
    for (int a = 0; a < 256; a++)
      if (grp_of(8'(a)) >= 0 && cm[grp_of(8'(a))]) m_ac[a] = m_sh[a];
    if (wr_en && grp_of(addr) >= 0) m_sh[addr] = wdata;
    for (int g = 0; g < 3; g++) m_pend[g] = st[g] || (m_pend[g] && !cm[g]);
    m_noise = nm_update || (m_noise && !clr);
    lbv = {lb_s, lb_e, lb_so, lb_eo, lb_r};
    m_lb = (lbv != m_lbprev) || (m_lb && !clr);
    m_lbprev = lbv;
  endtask

  // one clock: model follows the edge, output compared 2 ns later
  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    n_cmp++;
    if (rdata !== m_rdata) begin
      n_bad++;
      $display("FAIL %s t=%0t rdata actual=%02h expected=%02h", cur_req, $time, rdata, m_rdata);
    end
  endtask

  task automatic idle_in();
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    tko_main = 0; tko_sec = 0; tko_out = 0; nm_update = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); idle_in();
  endtask
  task automatic rd(input logic [7:0] a);
    rd_en = 1; addr = a; tick(); idle_in(); tick();
  endtask
  task automatic tko(input int g);
    tko_main = (g == 0); tko_sec = (g == 1); tko_out = (g == 2); tick(); idle_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    lb_s = 0; lb_e = 0; lb_so = 0; lb_eo = 0; lb_r = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    // R9 / R10: reset state, rdata idle value
    cur_req = "R10"; tick(); tick();
    cur_req = "R9";
    for (int a = 0; a < 8'h80; a++) rd(8'(a));   // also R8 on the holes

    cur_req = "R1";
    wr(8'h05, 8'hAA); rd(8'h05);                 // still 88h
    cur_req = "R3";
    wr(8'h0C, 8'h33); tko(0); rd(8'h0C);         // strobe w/o store: no commit
    cur_req = "R2";
    wr(8'h7E, 8'h01); rd(8'h7F);                 // pending bit 0
    cur_req = "R3";
    tko(0); rd(8'h05); rd(8'h0C); rd(8'h7F);
    cur_req = "R4";
    wr(8'h0B, 8'h11); wr(8'h7E, 8'h01); wr(8'h0B, 8'h22); rd(8'h7F);
    tko(0); rd(8'h0B);
    cur_req = "R3";
    wr(8'h21, 8'h5C);
    wr_en = 1; addr = 8'h7E; wdata = 8'h02; tko_sec = 1; tick(); idle_in();
    rd(8'h21); rd(8'h7F);
    tko(1); rd(8'h21); rd(8'h7F);
    cur_req = "R5";
    wr(8'h37, 8'hC3); wr(8'h7E, 8'h04);
    tko(0); tko(1); rd(8'h37); rd(8'h7F);
    wr(8'h12, 8'h0F); tko(2); rd(8'h37); rd(8'h12); rd(8'h7F);
    wr(8'h7E, 8'h07); rd(8'h7F); tko(2); rd(8'h7F); tko(0); tko(1); rd(8'h7F);
    rd(8'h12);
    cur_req = "R6";
    nm_update = 1; tick(); idle_in(); rd(8'h7F); rd(8'h7F);
    nm_update = 1; rd_en = 1; addr = 8'h7F; tick(); idle_in(); tick();
    rd(8'h7F); rd(8'h7F);
    cur_req = "R7";
    lb_s = 10'd37; tick(); rd(8'h7F); rd(8'h7F);
    lb_e = 10'd540; tick(); rd(8'h7F);
    lb_so = 1; tick(); rd(8'h7F);
    lb_eo = 1; tick(); rd(8'h7F);
    lb_r = 4'd9; tick(); rd(8'h7F); rd(8'h7F);
    lb_r = 4'd3; rd_en = 1; addr = 8'h7F; tick(); idle_in(); tick(); rd(8'h7F);
    cur_req = "R8";
    wr(8'h30, 8'h55); rd(8'h30); wr(8'h7F, 8'hFF); rd(8'h7F);
    wr(8'hFE, 8'h12); rd(8'hFE); rd(8'h7E); wr(8'h13, 8'h44); rd(8'h13);
    cur_req = "R10";
    wr(8'h06, 8'h99); tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule